// File: doc/BRIEF.md
# Frame Buffer Rectangle Fill Sequencer

This block turns one rectangle-fill command into a stream of single-halfword write requests for a 1024 x 512 halfword frame buffer. A command holds a 15-bit color, a raw X and Y position and a raw width and height, each 16 bits wide. The block accepts it over a valid/ready handshake. The raw values then go through the frame buffer's fixed masking and rounding rules. The X position is aligned down to a 16-pixel boundary, the width is rounded up to a multiple of 16, and the height is cut to nine bits.

The resulting rectangle is walked row by row, left to right. Each position produces one write request that carries a 19-bit address and the fill color. Requests wait while the memory side deasserts its ready. Coordinates wrap at the right and bottom edges of the frame buffer. A fill ignores the pixel write-protect setting, so every pixel of the rectangle receives its write.

When the last write has been taken, the block emits a one-cycle done pulse and becomes ready for the next command. A command whose effective width or height is zero produces only the done pulse.

Top module: `fill_rect_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `cmdReady` is 1 and `wrValid` and `fillDone` are 0.
- R2: The effective X origin is the raw X value masked to 10 bits with its low 4 bits cleared. The effective Y origin is the raw Y value masked to 9 bits. The first write of a fill targets that origin.
- R3: The effective width is the raw width masked to 10 bits and then rounded up to the next multiple of 16. A raw value of 400h therefore gives 0 columns, and raw values 3F1h through 3FFh give 1024 columns.
- R4: The effective height is the raw height masked to 9 bits. A raw height of 512 gives 0 rows, and at most 511 rows are written.
- R5: A command with zero effective width or zero effective height issues no writes, and `fillDone` pulses in the cycle after the command is accepted.
- R6: Writes are issued row by row, left to right. `wrAddr` = {row[8:0], column[9:0]}. Columns wrap modulo 1024 and rows wrap modulo 512.
- R7: Every write carries `wrData` = {1'b0, color}. Every pixel of the effective rectangle is written exactly once, with no pixel skipped for write protection.
- R8: A write is taken in a cycle where `wrValid` and `wrReady` are both 1. While `wrValid` is 1 and `wrReady` is 0, `wrValid`, `wrAddr` and `wrData` hold.
- R9: `fillDone` is a single-cycle pulse in the cycle after the final write is taken. `cmdReady` is 0 from command acceptance through the done pulse and returns to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Fill command present |
| cmdReady | output | 1 | Block can accept a command |
| cmdColor | input | 15 | Fill color |
| cmdX | input | 16 | Raw X position |
| cmdY | input | 16 | Raw Y position |
| cmdW | input | 16 | Raw width |
| cmdH | input | 16 | Raw height |
| wrValid | output | 1 | Write request present |
| wrReady | input | 1 | Memory side takes the write |
| wrAddr | output | 19 | Halfword address {row, column} |
| wrData | output | 16 | Halfword written |
| fillDone | output | 1 | One-cycle completion pulse |

## Verification
The widths are swept from 1 to 40 against heights of 1 to 3. Within this sweep, raw widths that land just below, on and just above a multiple of 16 are told apart by their write counts, and origins placed near the bottom edge expose any row-wrap fault. Single commands probe the width encodings 0, 400h, 3F1h, 3FFh and one with stray upper bits. They also probe the heights 0, 512 and 511, and the origin FFFFh, which separates masking, rounding and horizontal wrapping from the ordinary path. Half of the fills run with a pseudo-random stalling ready, so a lost or duplicated write shows up as an address mismatch or a wrong count. Every fill checks the exact cycle of the done pulse and the ready behavior around it.

// File: rtl/fill_pkg.sv
package fill_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } fill_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // capture a new command
    logic step;  // one write taken, advance position
  } fill_strobe_t;

endpackage

// File: rtl/fill_dp.sv
module fill_dp
  import fill_pkg::*;
#(
  parameter int XBITS    = 10,
  parameter int YBITS    = 9,
  parameter int CBITS    = 15,
  parameter int ABITS    = 4,
  parameter int RAW_BITS = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fill_strobe_t           strb,
  input  logic [CBITS-1:0]       cmdColor,
  input  logic [RAW_BITS-1:0]    cmdX,
  input  logic [RAW_BITS-1:0]    cmdY,
  input  logic [RAW_BITS-1:0]    cmdW,
  input  logic [RAW_BITS-1:0]    cmdH,
  output logic                   isEmpty,
  output logic                   lastPix,
  output logic [XBITS+YBITS-1:0] addr,
  output logic [CBITS:0]         data
);
  localparam int WBITS = XBITS + 1;
  localparam logic [WBITS-1:0] ROUND  = WBITS'((1 << ABITS) - 1);
  localparam logic [XBITS-1:0] ALOWER = XBITS'((1 << ABITS) - 1);

  logic [XBITS-1:0] wMasked, startX;
  logic [WBITS-1:0] effW;
  logic [YBITS-1:0] effH, startY;

  always_comb begin
    wMasked = XBITS'(cmdW);
    effW    = ({1'b0, wMasked} + ROUND) & ~ROUND;
    effH    = YBITS'(cmdH);
    startX  = XBITS'(cmdX) & ~ALOWER;
    startY  = YBITS'(cmdY);
    isEmpty = (effW == '0) || (effH == '0);
  end

  logic [CBITS-1:0] colorReg;
  logic [XBITS-1:0] baseX, curX;
  logic [YBITS-1:0] curY, rowLeft;
  logic [WBITS-1:0] widthReg, colLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colorReg <= '0;
      baseX    <= '0;
      curX     <= '0;
      curY     <= '0;
      rowLeft  <= '0;
      widthReg <= '0;
      colLeft  <= '0;
    end else if (strb.load) begin
      colorReg <= cmdColor;
      baseX    <= startX;
      curX     <= startX;
      curY     <= startY;
      widthReg <= effW;
      colLeft  <= effW - 1'b1;
      rowLeft  <= effH - 1'b1;
    end else if (strb.step) begin
      if (colLeft == '0) begin
        colLeft <= widthReg - 1'b1;
        curX    <= baseX;
        curY    <= curY + 1'b1;
        rowLeft <= rowLeft - 1'b1;
      end else begin
        colLeft <= colLeft - 1'b1;
        curX    <= curX + 1'b1;
      end
    end
  end

  assign lastPix = (colLeft == '0) && (rowLeft == '0);
  assign addr    = {curY, curX};
  assign data    = {1'b0, colorReg};

  // R2
  x_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> curX[ABITS-1:0] == '0);

  // R6
  row_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && colLeft == '0 && rowLeft != '0 |=>
      curY == $past(curY) + 1'b1 && curX == baseX);

  // R6
  col_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && colLeft != '0 |=>
      curX == $past(curX) + 1'b1 && curY == $past(curY));

endmodule

// File: rtl/fill_ctrl.sv
module fill_ctrl
  import fill_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic         wrReady,
  input  logic         isEmpty,
  input  logic         lastPix,
  output logic         cmdReady,
  output logic         wrValid,
  output logic         fillDone,
  output fill_strobe_t strb
);
  fill_state_e state, nextState;

  assign cmdReady  = (state == ST_IDLE);
  assign wrValid   = (state == ST_RUN);
  assign fillDone  = (state == ST_FIN);
  assign strb.load = cmdReady && cmdValid;
  assign strb.step = wrValid && wrReady;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (cmdValid) nextState = isEmpty ? ST_FIN : ST_RUN;
      ST_RUN:  if (wrReady && lastPix) nextState = ST_FIN;
      ST_FIN:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R5
  empty_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady && isEmpty |=> fillDone);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillDone |=> !fillDone && cmdReady);

  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady |=> !cmdReady);

  // R9
  last_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && wrReady && lastPix |=> fillDone);

endmodule

// File: rtl/fill_rect_seq.sv
module fill_rect_seq
  import fill_pkg::*;
#(
  parameter int XBITS    = 10,
  parameter int YBITS    = 9,
  parameter int CBITS    = 15,
  parameter int ABITS    = 4,
  parameter int RAW_BITS = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdValid,
  output logic                   cmdReady,
  input  logic [CBITS-1:0]       cmdColor,
  input  logic [RAW_BITS-1:0]    cmdX,
  input  logic [RAW_BITS-1:0]    cmdY,
  input  logic [RAW_BITS-1:0]    cmdW,
  input  logic [RAW_BITS-1:0]    cmdH,
  output logic                   wrValid,
  input  logic                   wrReady,
  output logic [XBITS+YBITS-1:0] wrAddr,
  output logic [CBITS:0]         wrData,
  output logic                   fillDone
);
  fill_strobe_t strb;
  logic isEmpty, lastPix;

  fill_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .wrReady  (wrReady),
    .isEmpty  (isEmpty),
    .lastPix  (lastPix),
    .cmdReady (cmdReady),
    .wrValid  (wrValid),
    .fillDone (fillDone),
    .strb     (strb)
  );

  fill_dp #(
    .XBITS(XBITS), .YBITS(YBITS), .CBITS(CBITS),
    .ABITS(ABITS), .RAW_BITS(RAW_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cmdColor (cmdColor),
    .cmdX     (cmdX),
    .cmdY     (cmdY),
    .cmdW     (cmdW),
    .cmdH     (cmdH),
    .isEmpty  (isEmpty),
    .lastPix  (lastPix),
    .addr     (wrAddr),
    .data     (wrData)
  );

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !wrReady |=> wrValid && $stable(wrAddr) && $stable(wrData));

  // R7
  data_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> !wrData[CBITS]);

endmodule

// File: tb/tb_fill_rect_seq.sv
module tb_fill_rect_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, cmdValid, cmdReady, wrValid, wrReady, fillDone;
  logic [14:0] cmdColor;
  logic [15:0] cmdX, cmdY, cmdW, cmdH, wrData;
  logic [18:0] wrAddr;

  fill_rect_seq dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdColor(cmdColor), .cmdX(cmdX), .cmdY(cmdY), .cmdW(cmdW), .cmdH(cmdH),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData),
    .fillDone(fillDone)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R9 watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic runFill(input string tag, input logic [14:0] col,
                         input logic [15:0] x, input logic [15:0] y,
                         input logic [15:0] w, input logic [15:0] h,
                         input bit stall);
    int ew, eh, x0, y0, total, k, guard, ex, ey;
    bit lastPrev;
    ew = ((int'(w) & 'h3FF) + 15) & ~15;
    eh = int'(h) & 'h1FF;
    x0 = int'(x) & 'h3F0;
    y0 = int'(y) & 'h1FF;
    total = (ew == 0 || eh == 0) ? 0 : ew * eh;
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdColor = col; cmdX = x; cmdY = y; cmdW = w; cmdH = h; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    k = 0; guard = 0; lastPrev = (total == 0);
    forever begin
      wrReady = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #1;
      if (fillDone) begin
        // R5 R7 write count, R9 done timing
        chk(k == total, {tag, " R7 write count"}, k, total);
        chk(lastPrev, {tag, " R9 done cycle"}, 0, 1);
        chk(!wrValid, {tag, " R9 no write with done"}, wrValid, 0);
        break;
      end
      lastPrev = 0;
      if (cmdReady) chk(0, {tag, " R9 ready while busy"}, 1, 0);
      if (wrValid && wrReady) begin
        if (k >= total) chk(0, {tag, " R7 extra write"}, k + 1, total);
        else begin
          ex = (x0 + k % ew) % 1024;
          ey = (y0 + k / ew) % 512;
          chk(int'(wrAddr) == ey * 1024 + ex,
              (k == 0) ? {tag, " R2 first address"} : {tag, " R6 address"},
              int'(wrAddr), ey * 1024 + ex);
          chk(wrData == {1'b0, col}, {tag, " R7 data"}, int'(wrData), int'(col));
        end
        k++;
        if (k == total) lastPrev = 1;
      end
      guard++;
      if (guard > total * 8 + 20) begin
        chk(0, {tag, " R9 done missing"}, k, total);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    #1;
    chk(cmdReady && !fillDone, {tag, " R9 ready after done"}, cmdReady, 1);
  endtask

  initial begin
    rstN = 1'b0; cmdValid = 1'b1; wrReady = 1'b1;
    cmdColor = '0; cmdX = '0; cmdY = '0; cmdW = 16'd16; cmdH = 16'd1;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(cmdReady && !wrValid && !fillDone, "R1 in reset", {cmdReady, wrValid, fillDone}, 4);
    cmdValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    // R1 after reset
    chk(cmdReady && !wrValid && !fillDone, "R1 after reset", {cmdReady, wrValid, fillDone}, 4);

    // R5 empty fills
    runFill("R5 w0", 15'h1234, 16'd32, 16'd7, 16'h0000, 16'd5, 0);
    runFill("R5 h0", 15'h0042, 16'd32, 16'd7, 16'd8, 16'h0000, 1);
    // R3 width encodings
    runFill("R3 w400", 15'h7FFF, 16'd0, 16'd0, 16'h0400, 16'd3, 0);
    runFill("R3 w3F1", 15'h2AAA, 16'h0123, 16'd10, 16'h03F1, 16'd1, 0);
    runFill("R3 w3FF", 15'h5555, 16'h0200, 16'd511, 16'h03FF, 16'd2, 1);
    runFill("R3 whigh", 15'h0F0F, 16'd48, 16'd2, 16'h1405, 16'd1, 1);
    // R4 height encodings
    runFill("R4 h512", 15'h3333, 16'd0, 16'd0, 16'd16, 16'd512, 0);
    runFill("R4 h203", 15'h1111, 16'd64, 16'd100, 16'd20, 16'h0203, 1);
    runFill("R4 h511", 15'h6666, 16'd1000, 16'd300, 16'd1, 16'd511, 0);
    // R2 origin masking and wrap
    runFill("R2 xyff", 15'h0001, 16'hFFFF, 16'hFFFF, 16'd40, 16'd2, 1);
    runFill("R2 xmid", 15'h7000, 16'h840F, 16'h8205, 16'd17, 16'd1, 0);
    // R6 R7 R8 sweep over widths and heights
    for (int w = 1; w <= 40; w++) begin
      for (int h = 1; h <= 3; h++) begin
        runFill("R8 sweep", 15'(w * 97 + h), 16'(w * 37), 16'(509 + h),
                16'(w), 16'(h), w[0]);
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule